// File: doc/BRIEF.md
# Performance Monitor Alert and Freeze Controller

This block owns the first control word of a performance-monitor unit and turns counter overflow into two separate actions. When the counter bank reports an overflow with a single-cycle pulse, the controller can freeze every counter by setting the global freeze bit in the control word. It can also raise an alert: the one-shot alert-enable bit is consumed and becomes an alert-occurred flag, and that flag holds a level-sensitive interrupt line high.

Software reads and writes the whole control word through a simple port. Every software write also reloads the interrupt line from the alert-occurred bit it writes, so writing a 0 there clears a pending interrupt and writing a 1 raises one. The current freeze bit is driven out continuously so that the counter bank can stop counting.

Top module: `pm_alert_ctl`

## Requirements
- R1: While reset is asserted, the control word reads as all zeros, the interrupt output is low and the freeze output is low.
- R2: A write with no overflow stores the written word, which appears on the read port one clock later; the freeze output always equals bit 0 (freeze) of the stored word.
- R3: A write sets the interrupt output to the written bit 3 (alert-occurred) one clock later: high if it is 1, low if it is 0.
- R4: An overflow pulse with bit 1 (freeze-on-overflow) set makes bit 0 and the freeze output 1 one clock later; with bit 1 clear, bit 0 is left as it was.
- R5: An overflow pulse with bit 2 (alert-enable) set clears bit 2, sets bit 3 and drives the interrupt output high, all one clock later.
- R6: An overflow pulse with bit 2 clear leaves bit 3 and the interrupt output unchanged.
- R7: The freeze action and the alert action are decided independently on the same overflow pulse; both take effect when both control bits are set.
- R8: A write in the same cycle as an overflow pulse is applied first, and the overflow update then acts on the written word, including the interrupt.
- R9: With neither a write nor an overflow pulse, the control word and the interrupt output keep their values.
- R10: An overflow pulse changes no bit of the control word other than bits 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cw_wr | input | 1 | Software write strobe for the control word |
| cw_wdata | input | 32 | Word to write |
| ovf_pulse | input | 1 | Overflow indication from the counter bank, one cycle per event |
| cw_rdata | output | 32 | Current control word |
| frz_out | output | 1 | Current global freeze bit, to the counter bank |
| pm_irq | output | 1 | Level-sensitive performance-monitor interrupt |

## Verification
The assertions check on every cycle that an overflow with alert-enable set raises the interrupt and converts the enable into the occurred flag, that an overflow with freeze-on-overflow set freezes, that a lone write loads the interrupt from the written bit, and that idle cycles change nothing. Only the bench's scenarios show the write-then-overflow ordering when both arrive together, that untouched bits survive an overflow, and that the reset values are right.

// File: rtl/pm_alert_ctl.sv
module pm_alert_ctl #(
  parameter int W       = 32,
  parameter int FRZ_BIT = 0,
  parameter int FOC_BIT = 1,
  parameter int AEN_BIT = 2,
  parameter int AOC_BIT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cw_wr,
  input  logic [W-1:0] cw_wdata,
  input  logic         ovf_pulse,
  output logic [W-1:0] cw_rdata,
  output logic         frz_out,
  output logic         pm_irq
);

  logic [W-1:0] cw_q, cw_base, cw_d;
  logic         irq_q, irq_d;

  assign cw_base = cw_wr ? cw_wdata : cw_q;

  always_comb begin
    cw_d  = cw_base;
    irq_d = cw_wr ? cw_wdata[AOC_BIT] : irq_q;
    if (ovf_pulse) begin
      if (cw_base[FOC_BIT]) cw_d[FRZ_BIT] = 1'b1;
      if (cw_base[AEN_BIT]) begin
        cw_d[AEN_BIT] = 1'b0;
        cw_d[AOC_BIT] = 1'b1;
        irq_d         = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      cw_q  <= cw_d;
      irq_q <= irq_d;
    end
  end

  assign cw_rdata = cw_q;
  assign frz_out  = cw_q[FRZ_BIT];
  assign pm_irq   = irq_q;

  p_alert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !cw_wr && cw_rdata[AEN_BIT]) |=> (pm_irq && cw_rdata[AOC_BIT] && !cw_rdata[AEN_BIT]));

  p_noalert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !cw_wr && !cw_rdata[AEN_BIT]) |=> ($stable(pm_irq) && $stable(cw_rdata[AOC_BIT])));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && !cw_wr && cw_rdata[FOC_BIT]) |=> frz_out);

  p_wr_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_wr && !ovf_pulse) |=> (pm_irq == $past(cw_wdata[AOC_BIT])));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cw_wr && !ovf_pulse) |=> ($stable(cw_rdata) && $stable(pm_irq)));

endmodule

// File: tb/tb_pm_alert_ctl.sv
module tb_pm_alert_ctl;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cw_wr = 1'b0;
  logic [W-1:0] cw_wdata = '0;
  logic         ovf_pulse = 1'b0;
  logic [W-1:0] cw_rdata;
  logic         frz_out, pm_irq;

  int total = 0, bad = 0;
  logic [W-1:0] m_cw = '0;
  logic         m_irq = 1'b0;

  always #4 clk = ~clk;

  pm_alert_ctl dut (.clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cw_wdata(cw_wdata),
                    .ovf_pulse(ovf_pulse), .cw_rdata(cw_rdata), .frz_out(frz_out), .pm_irq(pm_irq));

  function automatic logic [W-1:0] nxt_cw(logic [W-1:0] cur, logic wr, logic [W-1:0] wd, logic ov);
    logic [W-1:0] b = wr ? wd : cur;
    logic [W-1:0] r = b;
    if (ov && b[1]) r[0] = 1'b1;
    if (ov && b[2]) begin r[2] = 1'b0; r[3] = 1'b1; end
    return r;
  endfunction

  function automatic logic nxt_irq(logic [W-1:0] cur, logic irq, logic wr, logic [W-1:0] wd, logic ov);
    logic [W-1:0] b = wr ? wd : cur;
    logic r = wr ? wd[3] : irq;
    if (ov && b[2]) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [W-1:0] wd, logic ov, string tag);
    @(negedge clk);
    cw_wr = wr; cw_wdata = wd; ovf_pulse = ov;
    @(posedge clk);
    m_irq = nxt_irq(m_cw, m_irq, wr, wd, ov);
    m_cw  = nxt_cw(m_cw, wr, wd, ov);
    #1;
    chk(tag, "word", cw_rdata, m_cw);
    chk(tag, "irq", {31'd0, pm_irq}, {31'd0, m_irq});
    chk({tag, "/R2"}, "freeze", {31'd0, frz_out}, {31'd0, m_cw[0]});
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "word", cw_rdata, '0);
    chk("R1", "irq", {31'd0, pm_irq}, '0);
    chk("R1", "freeze", {31'd0, frz_out}, '0);
    rst_n = 1'b1;

    step(1, 32'hA5A0_0008, 0, "R3");
    step(0, '0, 0, "R9");
    step(1, 32'h0000_0000, 0, "R3");
    step(1, 32'h0000_0002, 0, "R2");
    step(0, '0, 1, "R4");
    step(1, 32'h0000_0000, 0, "R2");
    step(0, '0, 1, "R4");
    step(1, 32'h1230_0004, 0, "R2");
    step(0, '0, 1, "R5");
    step(0, '0, 1, "R6");
    step(1, 32'h0000_0000, 0, "R3");
    step(0, '0, 1, "R6");
    step(1, 32'hF000_0006, 0, "R2");
    step(0, '0, 1, "R7");
    step(1, 32'h0000_0008, 1, "R8");
    step(1, 32'h0000_0004, 1, "R8");
    step(1, 32'hFFFF_FFF0, 1, "R10");
    step(0, '0, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic wr = ($urandom % 4) == 0;
      logic ov = ($urandom % 3) == 0;
      logic [W-1:0] wd = $urandom;
      step(wr, wd, ov, wr && ov ? "R8" : ov ? "R10" : wr ? "R3" : "R9");
    end
    step(0, '0, 0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule